// File: doc/BRIEF.md
# Chainable Event Counter Bank

A bank of event counters for one slice of a cache performance monitor. Each counter picks one cache event strobe (or the clock itself) through an 8-bit event code and advances once per cycle in which that event is present, provided the counter and the whole bank are switched on. An odd-numbered counter can be tied to its even neighbour so that it counts the neighbour's wrap carries. The pair then acts as one 64-bit counter whose upper half moves in the same cycle as the lower half wraps.

Each counter has a sticky status flag. By default the flag is set on wraparound. In the per-counter toggle mode it is set on every change of the counter's top bit. The interrupt line is a level signal. It is high while any flagged counter also has its interrupt enabled. Software drives the bank through a simple register port. The port takes one request per cycle, with no back-pressure, so it has no ready signal. A read returns its data with a valid strobe on the cycle after the request. Writes take effect at the clock edge that samples them.

Top module: `ecb_bank`

## Requirements
- R1: After reset, every counter value, mask, status bit and the bank enable are zero, the interrupt line is low, and the control register (offset 0x500) reads 0.
- R2: The event code in the low 8 bits of counter n's code register (0x220 + 8n) selects what the counter counts. Code 0x01 counts every cycle. Codes 0x20 to 0x25 count strobes `ev_in[0]` to `ev_in[5]`, which are read hit, read miss, data-side read hit, data-side read miss, write hit and write miss. Any other code counts nothing.
- R3: While the bank enable (bit 0 of 0x500) is 0, no counter value changes unless it is written.
- R4: A counter advances only while its bit in the enable mask is 1. Writing to 0x508 sets the mask bits that are 1 in the data. Writing to 0x50C clears them. Zero bits have no effect. Reading either offset returns the mask.
- R5: When bit k of the chain register (0x718) is set for an odd k, counter k advances exactly when counter k−1 wraps from all ones to zero, in that same cycle, and it ignores its own event. Even bits of the chain register are ignored and read back as 0.
- R6: With bit n of the toggle-mode register (0x96C) clear, status bit n is set only when counter n wraps from all ones to zero.
- R7: With bit n of 0x96C set, status bit n is set each time counter n's bit 31 changes value through counting, in either direction.
- R8: Writing 1 to bit n of the status register (0x740) clears status bit n. Writing 0 has no effect. If a clear and a new status set occur in the same cycle, the bit stays set.
- R9: The interrupt enable mask is set through 0x510 and cleared through 0x514, with 1 bits acting and 0 bits ignored. `irq` is high exactly while some counter has both its status bit and its interrupt-enable bit set.
- R10: Writing counter n's value register (0x420 + 8n) loads the data. If the counter would also advance in that cycle, the written value wins.
- R11: Writing 1 to bit 1 of 0x500 clears all counter values, status bits, both enable masks and the chain register in one cycle. Bit 1 reads back as 0. Event codes and the toggle-mode register are kept, and bit 0 of the same write sets the bank enable.
- R12: Every read request produces exactly one `rd_vld` pulse on the next cycle, carrying the register contents as they were at the request. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Register request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (12) | Byte offset of the register |
| req_wdata | input | CW (32) | Write data |
| rd_vld | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | CW (32) | Read data |
| ev_in | input | NEV (6) | Cache event strobes, one bit per event kind |
| irq | output | 1 | Level interrupt: any status bit with its interrupt enabled |

## Verification
The bench chains a pair with the lower half two steps below its wrap and sets the upper half's own code to cycle counting. A design that let the upper half count its own event, or that carried one cycle late, would read back a wrong upper value. It loads a counter in the same cycle the counter steps, and it clears a status bit in the same cycle that a top-bit toggle sets it again. The wrong priority shows up as an off-by-one value or as a lost flag. It places a counter at 0x7FFFFFFF in both status modes, so a design that flags top-bit changes without the mode bit, or misses the falling edge from all ones, is caught. The bench also checks that the bank reset keeps event codes and the toggle-mode register but clears the interrupt mask.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  // register offsets (byte addresses)
  localparam int OFS_GCTL     = 'h500;
  localparam int OFS_CNTEN_S  = 'h508;
  localparam int OFS_CNTEN_C  = 'h50C;
  localparam int OFS_INTEN_S  = 'h510;
  localparam int OFS_INTEN_C  = 'h514;
  localparam int OFS_CHAIN    = 'h718;
  localparam int OFS_STATUS   = 'h740;
  localparam int OFS_TGLMODE  = 'h96C;
  localparam int OFS_VAL      = 'h420;
  localparam int OFS_CODE     = 'h220;
  localparam int REG_STRIDE   = 8;
  // event code map
  localparam int CODE_CYCLES  = 'h01;
  localparam int CODE_EV_BASE = 'h20;
endpackage

// File: rtl/ecb_evsel.sv
module ecb_evsel
  import ecb_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int NEV    = 6
) (
  input  logic [CODE_W-1:0] code,
  input  logic [NEV-1:0]    ev_in,
  output logic              hit
);
  always_comb begin
    hit = (code == CODE_W'(CODE_CYCLES));
    for (int j = 0; j < NEV; j++) begin
      if (code == CODE_W'(CODE_EV_BASE + j)) hit = ev_in[j];
    end
  end
endmodule

// File: rtl/ecb_slice.sv
module ecb_slice #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  input  logic          msb_mode,
  input  logic          flag_clr,
  output logic [CW-1:0] value,
  output logic          carry,
  output logic          flag
);
  logic moves, all_ones, low_ones, flag_set;

  always_comb begin
    moves    = step & ~load;
    all_ones = &value;
    low_ones = &value[CW-2:0];
    carry    = moves & all_ones;
    flag_set = moves & (msb_mode ? low_ones : all_ones);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= '0;
    else if (srst)     value <= '0;
    else if (load)     value <= load_val;
    else if (moves)    value <= value + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (srst)      flag <= 1'b0;
    else if (flag_set)  flag <= 1'b1;
    else if (flag_clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/ecb_bank.sv
module ecb_bank
  import ecb_pkg::*;
#(
  parameter int N      = 8,
  parameter int CW     = 32,
  parameter int AW     = 12,
  parameter int NEV    = 6,
  parameter int CODE_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_wdata,
  output logic          rd_vld,
  output logic [CW-1:0] rd_data,
  input  logic [NEV-1:0] ev_in,
  output logic          irq
);
  localparam int FLAT_W = N * CW;

  logic wr_go, rd_go, srst;
  logic en_q;
  logic [N-1:0] cnten_q, inten_q, chain_q, tgl_q, ovs_q, ovs_clr;
  logic [N-1:0] hit, src, step, carry, odd_mask;
  logic [CW-1:0] cnt_q [N];
  logic [CODE_W-1:0] code_q [N];
  logic [FLAT_W-1:0] cnt_flat;
  logic [CW-1:0] rd_next;

  assign wr_go = req_vld & req_wr;
  assign rd_go = req_vld & ~req_wr;
  assign srst  = wr_go && (req_addr == AW'(OFS_GCTL)) && req_wdata[1];
  assign ovs_clr = (wr_go && req_addr == AW'(OFS_STATUS)) ? req_wdata[N-1:0] : '0;

  // bank-level control and masks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cnten_q <= '0;
      inten_q <= '0;
      chain_q <= '0;
      tgl_q   <= '0;
    end else begin
      if (wr_go && req_addr == AW'(OFS_GCTL))    en_q  <= req_wdata[0];
      if (wr_go && req_addr == AW'(OFS_TGLMODE)) tgl_q <= req_wdata[N-1:0];
      if (srst) begin
        cnten_q <= '0;
        inten_q <= '0;
        chain_q <= '0;
      end else if (wr_go) begin
        if (req_addr == AW'(OFS_CNTEN_S)) cnten_q <= cnten_q | req_wdata[N-1:0];
        if (req_addr == AW'(OFS_CNTEN_C)) cnten_q <= cnten_q & ~req_wdata[N-1:0];
        if (req_addr == AW'(OFS_INTEN_S)) inten_q <= inten_q | req_wdata[N-1:0];
        if (req_addr == AW'(OFS_INTEN_C)) inten_q <= inten_q & ~req_wdata[N-1:0];
        if (req_addr == AW'(OFS_CHAIN))   chain_q <= req_wdata[N-1:0] & odd_mask;
      end
    end
  end

  // per-counter lanes
  for (genvar i = 0; i < N; i++) begin : g_lane
    logic load_i;
    assign load_i      = wr_go && (req_addr == AW'(OFS_VAL + i * REG_STRIDE));
    assign odd_mask[i] = 1'(i % 2);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q[i] <= '0;
      else if (wr_go && req_addr == AW'(OFS_CODE + i * REG_STRIDE))
        code_q[i] <= req_wdata[CODE_W-1:0];
    end

    ecb_evsel #(.CODE_W(CODE_W), .NEV(NEV)) u_sel (
      .code (code_q[i]),
      .ev_in(ev_in),
      .hit  (hit[i])
    );

    if (i % 2 == 1) begin : g_odd
      assign src[i] = chain_q[i] ? carry[i-1] : hit[i];
    end else begin : g_even
      assign src[i] = hit[i];
    end

    assign step[i] = en_q & cnten_q[i] & src[i];

    ecb_slice #(.CW(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst),
      .load    (load_i),
      .load_val(req_wdata),
      .step    (step[i]),
      .msb_mode(tgl_q[i]),
      .flag_clr(ovs_clr[i]),
      .value   (cnt_q[i]),
      .carry   (carry[i]),
      .flag    (ovs_q[i])
    );

    assign cnt_flat[i*CW +: CW] = cnt_q[i];
  end

  // read mux
  always_comb begin
    rd_next = '0;
    if (req_addr == AW'(OFS_GCTL))    rd_next = CW'(en_q);
    if (req_addr == AW'(OFS_CNTEN_S) || req_addr == AW'(OFS_CNTEN_C)) rd_next = CW'(cnten_q);
    if (req_addr == AW'(OFS_INTEN_S) || req_addr == AW'(OFS_INTEN_C)) rd_next = CW'(inten_q);
    if (req_addr == AW'(OFS_CHAIN))   rd_next = CW'(chain_q);
    if (req_addr == AW'(OFS_STATUS))  rd_next = CW'(ovs_q);
    if (req_addr == AW'(OFS_TGLMODE)) rd_next = CW'(tgl_q);
    for (int i = 0; i < N; i++) begin
      if (req_addr == AW'(OFS_VAL + i * REG_STRIDE))  rd_next = cnt_q[i];
      if (req_addr == AW'(OFS_CODE + i * REG_STRIDE)) rd_next = CW'(code_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_go;
      if (rd_go) rd_data <= rd_next;
    end
  end

  assign irq = |(ovs_q & inten_q);
endmodule

// File: rtl/ecb_bank_chk.sv
module ecb_bank_chk
  import ecb_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = 32,
  parameter int AW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_vld,
  input logic            req_wr,
  input logic [AW-1:0]   req_addr,
  input logic            wbit1,
  input logic            rd_vld,
  input logic            irq,
  input logic            en_q,
  input logic [N-1:0]    cnten_q,
  input logic [N-1:0]    inten_q,
  input logic [N-1:0]    ovs_q,
  input logic [N-1:0]    chain_q,
  input logic [N*CW-1:0] cnt_flat
);
  AST_HALT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(req_vld && req_wr)) |=> $stable(cnt_flat)); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_vld && req_wr) |=> ((ovs_q & $past(ovs_q)) == $past(ovs_q))); // R8

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovs_q != '0 && inten_q != '0)); // R9

  AST_BANK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_wr && req_addr == AW'(OFS_GCTL) && wbit1) |=>
      (cnten_q == '0 && inten_q == '0 && ovs_q == '0 && chain_q == '0 && cnt_flat == '0)); // R11

  AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_wr) |=> rd_vld); // R12

  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_vld && !req_wr) |=> !rd_vld); // R12
endmodule

bind ecb_bank ecb_bank_chk #(.N(N), .CW(CW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_vld (req_vld),
  .req_wr  (req_wr),
  .req_addr(req_addr),
  .wbit1   (req_wdata[1]),
  .rd_vld  (rd_vld),
  .irq     (irq),
  .en_q    (en_q),
  .cnten_q (cnten_q),
  .inten_q (inten_q),
  .ovs_q   (ovs_q),
  .chain_q (chain_q),
  .cnt_flat(cnt_flat)
);

// File: tb/tb_ecb_bank.sv
module tb_ecb_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_GCTL = 12'h500, A_CEN_S = 12'h508, A_CEN_C = 12'h50C,
                          A_IEN_S = 12'h510, A_IEN_C = 12'h514, A_CHAIN = 12'h718,
                          A_STAT = 12'h740, A_TGL = 12'h96C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_vld = 1'b0, req_wr = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_vld, irq;
  logic [31:0] rd_data;
  logic [5:0] ev_in = '0;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecb_bank dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_vld(rd_vld),
    .rd_data(rd_data), .ev_in(ev_in), .irq(irq)
  );

  function automatic logic [11:0] a_val(int n);  return 12'(12'h420 + 8 * n); endfunction
  function automatic logic [11:0] a_code(int n); return 12'(12'h220 + 8 * n); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(logic [11:0] a, logic [31:0] d);
    req_vld = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_vld = 1'b0; req_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    req_vld = 1'b1; req_wr = 1'b0; req_addr = a;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  // monitor: pop expected read results as they come out
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected rd_vld", 32'h1, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    rd(A_GCTL, 0, "R1 gctl");
    rd(a_val(0), 0, "R1 val0");
    rd(A_STAT, 0, "R1 status");
    rd(A_CEN_S, 0, "R1 cnten");

    // R2 / R4 event selection and enable mask
    wr(a_code(0), 32'h01); wr(a_code(2), 32'h21); wr(a_code(3), 32'h25);
    wr(a_code(4), 32'h30); wr(a_code(5), 32'h01);
    wr(A_CEN_S, 32'h1D); wr(A_CEN_S, 32'h0);
    ev_in = 6'b000010;
    wr(A_GCTL, 1); idle(4); wr(A_GCTL, 0);        // 5 counting edges
    rd(a_val(0), 5, "R2 cycles");
    rd(a_val(2), 5, "R2 read miss");
    rd(a_val(3), 0, "R2 write miss idle");
    rd(a_val(4), 0, "R2 unknown code");
    rd(a_val(5), 0, "R4 disabled counter");
    rd(A_CEN_S, 32'h1D, "R4 set mask");
    wr(A_CEN_C, 32'h01); wr(A_CEN_C, 32'h0);
    rd(A_CEN_C, 32'h1C, "R4 clear mask");

    // R3 bank off
    idle(5);
    rd(a_val(2), 5, "R3 halted");

    // R10 direct load and priority over step
    wr(a_val(1), 32'h1234);
    rd(a_val(1), 32'h1234, "R10 load");
    wr(A_CEN_S, 32'h01);
    wr(A_GCTL, 1); wr(a_val(0), 100); wr(A_GCTL, 0);
    rd(a_val(0), 101, "R10 load wins");

    // R11 bank clear
    ev_in = '0;
    wr(A_GCTL, 2);
    rd(A_GCTL, 0, "R11 gctl");
    rd(a_val(0), 0, "R11 val0");
    rd(a_val(1), 0, "R11 val1");
    rd(A_CEN_S, 0, "R11 cnten");

    // R5 / R6 chaining and wrap status
    wr(A_CHAIN, 32'hFF);
    rd(A_CHAIN, 32'hAA, "R5 odd only");
    wr(A_CHAIN, 32'h02);
    wr(a_code(0), 1); wr(a_code(1), 1); wr(a_code(2), 1);
    wr(a_val(0), 32'hFFFF_FFFE); wr(a_val(1), 7); wr(a_val(2), 32'h7FFF_FFFF);
    wr(A_CEN_S, 32'h07);
    wr(A_GCTL, 1); idle(1); wr(A_GCTL, 0);        // 2 counting edges
    rd(a_val(0), 0, "R5 low wrapped");
    rd(a_val(1), 8, "R5 high carried");
    rd(a_val(2), 32'h8000_0001, "R6 value");
    rd(A_STAT, 32'h01, "R6 wrap only");

    // R7 toggle mode
    wr(A_GCTL, 2);
    wr(A_TGL, 32'h0C); wr(a_code(3), 1);
    wr(a_val(2), 32'h7FFF_FFFF); wr(a_val(3), 32'hFFFF_FFFF);
    wr(A_CEN_S, 32'h0C);
    wr(A_GCTL, 1); wr(A_GCTL, 0);                 // 1 counting edge
    rd(A_STAT, 32'h0C, "R7 both edges");
    rd(a_val(2), 32'h8000_0000, "R7 value");

    // R8 write-one-to-clear and set priority
    wr(A_STAT, 32'h04);
    rd(A_STAT, 32'h08, "R8 w1c");
    wr(A_STAT, 32'h08);
    wr(A_CEN_C, 32'h04);
    wr(a_val(3), 32'h7FFF_FFFF);
    wr(A_GCTL, 1); wr(A_STAT, 32'h08); wr(A_GCTL, 0);
    rd(A_STAT, 32'h08, "R8 set wins");
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h08, "R8 zero no effect");

    // R9 interrupt level
    check("R9 irq masked", 32'(irq), 32'h0);
    wr(A_IEN_S, 32'h08);
    check("R9 irq on", 32'(irq), 32'h1);
    wr(A_IEN_S, 32'h04); wr(A_IEN_C, 32'h08);
    check("R9 irq off", 32'(irq), 32'h0);
    rd(A_IEN_S, 32'h04, "R9 inten mask");
    wr(A_IEN_S, 32'h08);
    check("R9 irq again", 32'(irq), 32'h1);

    // R11 keeps codes and toggle mode, clears interrupt mask
    wr(A_GCTL, 2);
    check("R11 irq", 32'(irq), 32'h0);
    rd(A_IEN_C, 0, "R11 inten");
    rd(A_TGL, 32'h0C, "R11 toggle kept");
    rd(a_code(3), 32'h01, "R11 code kept");

    // R12 every read answered
    idle(3);
    check("R12 pending reads", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule